// File: doc/BRIEF.md
# Client DMA Fence and Hot-Reset Controller

This block sits between a set of memory clients and the memory arbiter. For every client it decides whether a new request is accepted, counts the transactions that client still has in flight, and drives an active-low hot-reset line. Software uses it to take a client out of service safely. It first closes the client's request gate. It then polls the client's status word until the in-flight count reads zero. Next it clears the client's reset bit, and later it sets the reset bit and then the gate bit again.

Registers are reached through a simple word interface with a write strobe and combinational read data. One shared word holds the request-gate bits, one client per bit. A second shared word holds the hot-reset bits, again one client per bit. Each client also has a read-only status word that returns its in-flight count. A gate bit of 1 lets requests through, and a reset bit of 1 keeps the client out of reset.

Top module: `client_fence`

## Requirements
- R1: The gate word is at byte offset 0x000, and client i uses bit i. A write takes effect from the next cycle. While bit i is 0, reqAccept[i] stays low. Once bit i is 1, requests from client i can be accepted again.
- R2: reqAccept[i] is high in the same cycle exactly when reqValid[i] is high, gate bit i is 1, reset bit i is 1 and client i's in-flight count is below its maximum.
- R3: The reset word is at byte offset 0x004, and client i uses bit i. Writing 0 to bit i drives clientResetN[i] low from the next cycle. Writing 1 releases it. clientResetN always equals the reset word.
- R4: After rstN, the gate word and the reset word both read with all client bits set (0x7FFF for 15 clients). Every clientResetN line is high and every in-flight count is zero.
- R5: The status word of client i is at byte offset 0x040 + 4*i. It reads that client's in-flight count. The count rises by one on an accepted request and falls by one on a completion strobe. It is unchanged when both occur in the same cycle. It reads zero only when the client is idle.
- R6: A completion strobe while the count is zero leaves the count at zero.
- R7: When a client's count is at its maximum (2^CNT_W - 1, which is 15 by default), further requests from that client are not accepted.
- R8: Completions keep decrementing the count while the client's gate bit or reset bit is 0.
- R9: The following all read as 0:
  - addresses that map to no register;
  - misaligned status addresses;
  - status words for indices at or above the client count;
  - gate-word and reset-word bits above the client count, which writes do not change.
- R10: regRdata follows regAddr in the same cycle, with no read latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W (9) | Register byte address |
| regWdata | input | DATA_W (32) | Register write data |
| regRdata | output | DATA_W (32) | Register read data for regAddr |
| reqValid | input | NUM_CLIENTS (15) | Per-client request valid |
| cplStrobe | input | NUM_CLIENTS (15) | Per-client completion pulse |
| reqAccept | output | NUM_CLIENTS (15) | Per-client request accept |
| clientResetN | output | NUM_CLIENTS (15) | Per-client active-low hot reset |

## Verification
Each cycle, a behavioural model of the gate, the reset word and the per-client counts is compared with reqAccept, clientResetN and regRdata.

Wrong gate or reset state shows on reqAccept or clientResetN one cycle after the write that caused it. A count that drifts stays hidden until its status word is read, or until a full client refuses a request too early or too late. For that reason the bench reads status words right after bursts, after completions on blocked clients, and after completions at zero. A decode error appears at once on regRdata for the address that is driven.

// File: rtl/client_fence_pkg.sv
package client_fence_pkg;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_GATE   = 2'd1,
    RD_HOLD   = 2'd2,
    RD_STATUS = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   gateWr;
    logic   holdWr;
    rdSel_e rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/client_fence_counter.sv
module client_fence_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] count,
  output logic             full
);

  logic isZero;

  assign isZero = (count == '0);
  assign full   = (count == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (inc && !dec) begin
      count <= count + 1'b1;
    end else if (!inc && dec && !isZero) begin
      count <= count - 1'b1;
    end
  end

endmodule

// File: rtl/client_fence_decode.sv
module client_fence_decode
  import client_fence_pkg::*;
#(
  parameter int NUM_CLIENTS = 15,
  parameter int ADDR_W      = 9,
  parameter int IDX_W       = 4,
  parameter int GATE_OFS    = 'h000,
  parameter int HOLD_OFS    = 'h004,
  parameter int STATUS_BASE = 'h040
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrobe_t       strobe,
  output logic [IDX_W-1:0]  statusIdx
);

  localparam logic [ADDR_W-1:0] GATE_A   = ADDR_W'(GATE_OFS);
  localparam logic [ADDR_W-1:0] HOLD_A   = ADDR_W'(HOLD_OFS);
  localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(STATUS_BASE);
  localparam logic [ADDR_W-1:0] NUM_A    = ADDR_W'(NUM_CLIENTS);

  logic [ADDR_W-1:0] offs;
  logic              inStatus;

  always_comb begin
    offs      = regAddr - STATUS_A;
    inStatus  = (regAddr >= STATUS_A) && (offs[1:0] == 2'b00) && ((offs >> 2) < NUM_A);
    statusIdx = offs[IDX_W+1:2];

    strobe.gateWr = regWrEn && (regAddr == GATE_A);
    strobe.holdWr = regWrEn && (regAddr == HOLD_A);

    if (regAddr == GATE_A) begin
      strobe.rdSel = RD_GATE;
    end else if (regAddr == HOLD_A) begin
      strobe.rdSel = RD_HOLD;
    end else if (inStatus) begin
      strobe.rdSel = RD_STATUS;
    end else begin
      strobe.rdSel = RD_NONE;
    end
  end

endmodule

// File: rtl/client_fence_path.sv
module client_fence_path
  import client_fence_pkg::*;
#(
  parameter int NUM_CLIENTS = 15,
  parameter int CNT_W       = 4,
  parameter int DATA_W      = 32,
  parameter int IDX_W       = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobe_t            strobe,
  input  logic [IDX_W-1:0]       statusIdx,
  input  logic [NUM_CLIENTS-1:0] wrBits,
  input  logic [NUM_CLIENTS-1:0] reqValid,
  input  logic [NUM_CLIENTS-1:0] cplStrobe,
  output logic [NUM_CLIENTS-1:0] reqAccept,
  output logic [NUM_CLIENTS-1:0] holdQ,
  output logic [DATA_W-1:0]      rdData
);

  logic [NUM_CLIENTS-1:0]       gateQ;
  logic [NUM_CLIENTS-1:0]       fullVec;
  logic [NUM_CLIENTS*CNT_W-1:0] cntFlat;

  // Gate and reset words: all ones after reset, full client-width writes.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateQ <= '1;
      holdQ <= '1;
    end else begin
      if (strobe.gateWr) gateQ <= wrBits;
      if (strobe.holdWr) holdQ <= wrBits;
    end
  end

  assign reqAccept = reqValid & gateQ & holdQ & ~fullVec;

  // One in-flight counter per client; completions are never gated.
  for (genvar i = 0; i < NUM_CLIENTS; i++) begin : g_client
    client_fence_counter #(
      .CNT_W(CNT_W)
    ) u_cnt (
      .clk  (clk),
      .rstN (rstN),
      .inc  (reqAccept[i]),
      .dec  (cplStrobe[i]),
      .count(cntFlat[i*CNT_W +: CNT_W]),
      .full (fullVec[i])
    );
  end

  always_comb begin
    unique case (strobe.rdSel)
      RD_GATE:   rdData = DATA_W'(gateQ);
      RD_HOLD:   rdData = DATA_W'(holdQ);
      RD_STATUS: rdData = DATA_W'(cntFlat[int'(statusIdx)*CNT_W +: CNT_W]);
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/client_fence.sv
module client_fence
  import client_fence_pkg::*;
#(
  parameter int NUM_CLIENTS = 15,
  parameter int CNT_W       = 4,
  parameter int ADDR_W      = 9,
  parameter int DATA_W      = 32,
  parameter int GATE_OFS    = 'h000,
  parameter int HOLD_OFS    = 'h004,
  parameter int STATUS_BASE = 'h040
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWrEn,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic [DATA_W-1:0]      regWdata,
  output logic [DATA_W-1:0]      regRdata,
  input  logic [NUM_CLIENTS-1:0] reqValid,
  input  logic [NUM_CLIENTS-1:0] cplStrobe,
  output logic [NUM_CLIENTS-1:0] reqAccept,
  output logic [NUM_CLIENTS-1:0] clientResetN
);

  localparam int IDX_W = (NUM_CLIENTS > 1) ? $clog2(NUM_CLIENTS) : 1;

  ctrlStrobe_t      strobe;
  logic [IDX_W-1:0] statusIdx;

  client_fence_decode #(
    .NUM_CLIENTS(NUM_CLIENTS),
    .ADDR_W     (ADDR_W),
    .IDX_W      (IDX_W),
    .GATE_OFS   (GATE_OFS),
    .HOLD_OFS   (HOLD_OFS),
    .STATUS_BASE(STATUS_BASE)
  ) u_decode (
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .strobe   (strobe),
    .statusIdx(statusIdx)
  );

  client_fence_path #(
    .NUM_CLIENTS(NUM_CLIENTS),
    .CNT_W      (CNT_W),
    .DATA_W     (DATA_W),
    .IDX_W      (IDX_W)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .statusIdx(statusIdx),
    .wrBits   (regWdata[NUM_CLIENTS-1:0]),
    .reqValid (reqValid),
    .cplStrobe(cplStrobe),
    .reqAccept(reqAccept),
    .holdQ    (clientResetN),
    .rdData   (regRdata)
  );

endmodule

// File: rtl/client_fence_checker.sv
module client_fence_checker #(
  parameter int NUM_CLIENTS = 15,
  parameter int CNT_W       = 4,
  parameter int ADDR_W      = 9,
  parameter int GATE_OFS    = 'h000,
  parameter int HOLD_OFS    = 'h004
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         regWrEn,
  input logic [ADDR_W-1:0]            regAddr,
  input logic [NUM_CLIENTS-1:0]       wrBits,
  input logic [NUM_CLIENTS-1:0]       reqValid,
  input logic [NUM_CLIENTS-1:0]       cplStrobe,
  input logic [NUM_CLIENTS-1:0]       reqAccept,
  input logic [NUM_CLIENTS-1:0]       clientResetN,
  input logic [NUM_CLIENTS*CNT_W-1:0] cntFlat
);

  localparam logic [ADDR_W-1:0] GATE_A = ADDR_W'(GATE_OFS);
  localparam logic [ADDR_W-1:0] HOLD_A = ADDR_W'(HOLD_OFS);

  // R1: a cleared gate bit forbids acceptance in the following cycle
  p_gate_blocks_r1: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == GATE_A) |=> ((reqAccept & ~$past(wrBits)) == '0));

  // R2: accept only with valid and out of reset
  p_accept_needs_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((reqAccept & ~reqValid) == '0));
  p_accept_needs_release_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((reqAccept & ~clientResetN) == '0));

  // R3: reset lines follow the reset-word write one cycle later
  p_hold_follows_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == HOLD_A) |=> (clientResetN == $past(wrBits)));

  for (genvar i = 0; i < NUM_CLIENTS; i++) begin : g_chk
    // R5: an accepted request alone raises the count by one
    p_count_up_r5: assert property (@(posedge clk) disable iff (!rstN)
      (reqAccept[i] && !cplStrobe[i]) |=>
        (cntFlat[i*CNT_W +: CNT_W] == CNT_W'($past(cntFlat[i*CNT_W +: CNT_W]) + 1'b1)));
    // R6: completion at zero keeps zero
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rstN)
      (cntFlat[i*CNT_W +: CNT_W] == '0 && cplStrobe[i] && !reqAccept[i]) |=>
        (cntFlat[i*CNT_W +: CNT_W] == '0));
    // R7: a full counter refuses requests
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
      (cntFlat[i*CNT_W +: CNT_W] == {CNT_W{1'b1}}) |-> !reqAccept[i]);
    // R8: completion alone lowers a nonzero count, gated or not
    p_drain_when_blocked_r8: assert property (@(posedge clk) disable iff (!rstN)
      (cntFlat[i*CNT_W +: CNT_W] != '0 && cplStrobe[i] && !reqAccept[i]) |=>
        (cntFlat[i*CNT_W +: CNT_W] == CNT_W'($past(cntFlat[i*CNT_W +: CNT_W]) - 1'b1)));
  end

endmodule

bind client_fence client_fence_checker #(
  .NUM_CLIENTS(NUM_CLIENTS),
  .CNT_W      (CNT_W),
  .ADDR_W     (ADDR_W),
  .GATE_OFS   (GATE_OFS),
  .HOLD_OFS   (HOLD_OFS)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .regWrEn     (regWrEn),
  .regAddr     (regAddr),
  .wrBits      (regWdata[NUM_CLIENTS-1:0]),
  .reqValid    (reqValid),
  .cplStrobe   (cplStrobe),
  .reqAccept   (reqAccept),
  .clientResetN(clientResetN),
  .cntFlat     (u_path.cntFlat)
);

// File: tb/client_fence_bench.sv
module client_fence_bench;

  localparam int N    = 15;
  localparam int MAXC = 15;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [8:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [N-1:0] reqValid = '0;
  logic [N-1:0] cplStrobe = '0;
  logic [N-1:0] reqAccept;
  logic [N-1:0] clientResetN;

  always #10 clk = ~clk;

  client_fence u_client_fence (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .reqValid(reqValid),
    .cplStrobe(cplStrobe), .reqAccept(reqAccept), .clientResetN(clientResetN)
  );

  // Behavioural model
  logic [N-1:0] gateM = '1;
  logic [N-1:0] holdM = '1;
  int cntM [N];
  int errors = 0;
  int checks = 0;
  logic [31:0]  rdo;
  logic [N-1:0] acco;
  logic [N-1:0] rno;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] expRd(input logic [8:0] a);
    int ai;
    ai = int'(a);
    if (ai == 0) return 32'(gateM);
    if (ai == 4) return 32'(holdM);
    if (ai >= 64 && ai < 64 + 4*N && ai % 4 == 0) return 32'(cntM[(ai-64)/4]);
    return 32'h0;
  endfunction

  function automatic string rdTag(input logic [8:0] a);
    int ai;
    ai = int'(a);
    if (ai == 0) return "R1";
    if (ai == 4) return "R3";
    if (ai >= 64 && ai < 64 + 4*N && ai % 4 == 0) return "R5";
    return "R9";
  endfunction

  function automatic logic [N-1:0] expAcc(input logic [N-1:0] v);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = v[i] && gateM[i] && holdM[i] && (cntM[i] < MAXC);
    return r;
  endfunction

  // One clock: drive at negedge, compare before the edge, update model at edge.
  task automatic cyc(input logic we, input logic [8:0] a, input logic [31:0] wd,
                     input logic [N-1:0] v, input logic [N-1:0] c,
                     output logic [31:0] ro, output logic [N-1:0] ao, output logic [N-1:0] rn);
    logic [N-1:0] ea;
    @(negedge clk);
    regWrEn = we; regAddr = a; regWdata = wd; reqValid = v; cplStrobe = c;
    #2;
    ea = expAcc(v);
    chk(reqAccept === ea, "R2", 32'(reqAccept), 32'(ea));
    chk(clientResetN === holdM, "R3", 32'(clientResetN), 32'(holdM));
    chk(regRdata === expRd(a), rdTag(a), regRdata, expRd(a));
    ro = regRdata; ao = reqAccept; rn = clientResetN;
    @(posedge clk);
    if (we && a == 9'h000) gateM = wd[N-1:0];
    if (we && a == 9'h004) holdM = wd[N-1:0];
    for (int i = 0; i < N; i++) begin
      if (ea[i] && !c[i]) cntM[i]++;
      else if (!ea[i] && c[i] && cntM[i] > 0) cntM[i]--;
    end
  endtask

  task automatic idle(input logic [8:0] a);
    cyc(1'b0, a, 32'h0, '0, '0, rdo, acco, rno);
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) cntM[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R4 / R10: reset state, read data valid in the cycle the address is driven
    idle(9'h000); chk(rdo == 32'h7FFF, "R4 R10 gate after reset", rdo, 32'h7FFF);
    idle(9'h004); chk(rdo == 32'h7FFF, "R4 reset word after reset", rdo, 32'h7FFF);
    chk(rno == 15'h7FFF, "R4 reset lines", 32'(rno), 32'h7FFF);
    idle(9'h048); chk(rdo == 32'h0, "R4 count after reset", rdo, 32'h0);

    // R5: three accepts on client 2
    for (int k = 0; k < 3; k++) begin
      cyc(1'b0, 9'h048, 32'h0, 15'h0004, '0, rdo, acco, rno);
      chk(acco == 15'h0004, "R2 accept client 2", 32'(acco), 32'h4);
    end
    idle(9'h048); chk(rdo == 32'd3, "R5 count 3", rdo, 32'd3);

    // R1: block client 2, R8: completions still drain
    cyc(1'b1, 9'h000, 32'h7FFB, '0, '0, rdo, acco, rno);
    cyc(1'b0, 9'h048, 32'h0, 15'h0004, 15'h0004, rdo, acco, rno);
    chk(acco == 15'h0, "R1 blocked client 2", 32'(acco), 32'h0);
    idle(9'h048); chk(rdo == 32'd2, "R8 drain while blocked", rdo, 32'd2);
    cyc(1'b0, 9'h048, 32'h0, '0, 15'h0004, rdo, acco, rno);
    cyc(1'b0, 9'h048, 32'h0, '0, 15'h0004, rdo, acco, rno);
    idle(9'h048); chk(rdo == 32'd0, "R5 idle reads zero", rdo, 32'd0);
    cyc(1'b1, 9'h000, 32'h7FFF, '0, '0, rdo, acco, rno);
    cyc(1'b0, 9'h000, 32'h0, 15'h0004, '0, rdo, acco, rno);
    chk(acco == 15'h0004, "R1 unblocked client 2", 32'(acco), 32'h4);
    cyc(1'b0, 9'h000, 32'h0, '0, 15'h0004, rdo, acco, rno);

    // R6: completion at zero
    cyc(1'b0, 9'h054, 32'h0, '0, 15'h0020, rdo, acco, rno);
    idle(9'h054); chk(rdo == 32'd0, "R6 no underflow", rdo, 32'd0);

    // R7: fill client 7
    for (int k = 0; k < 16; k++) cyc(1'b0, 9'h05C, 32'h0, 15'h0080, '0, rdo, acco, rno);
    cyc(1'b0, 9'h05C, 32'h0, 15'h0080, '0, rdo, acco, rno);
    chk(acco == 15'h0, "R7 full refuses", 32'(acco), 32'h0);
    chk(rdo == 32'd15, "R7 count saturated", rdo, 32'd15);
    cyc(1'b0, 9'h05C, 32'h0, 15'h0080, 15'h0080, rdo, acco, rno);
    idle(9'h05C); chk(rdo == 32'd14, "R7 full plus completion", rdo, 32'd14);
    for (int k = 0; k < 14; k++) cyc(1'b0, 9'h05C, 32'h0, '0, 15'h0080, rdo, acco, rno);

    // R3 / R9: hot reset client 0, upper bits ignored
    cyc(1'b1, 9'h004, 32'hFFFF_7FFE, '0, '0, rdo, acco, rno);
    cyc(1'b0, 9'h004, 32'h0, 15'h0001, '0, rdo, acco, rno);
    chk(rno == 15'h7FFE, "R3 client 0 in reset", 32'(rno), 32'h7FFE);
    chk(rdo == 32'h7FFE, "R9 upper bits dropped", rdo, 32'h7FFE);
    chk(acco == 15'h0, "R2 no accept in reset", 32'(acco), 32'h0);
    cyc(1'b1, 9'h004, 32'h0000_7FFF, '0, '0, rdo, acco, rno);
    idle(9'h004); chk(rno == 15'h7FFF, "R3 released", 32'(rno), 32'h7FFF);

    // R9: unmapped and out-of-range reads
    idle(9'h100); chk(rdo == 32'h0, "R9 unmapped", rdo, 32'h0);
    idle(9'h07C); chk(rdo == 32'h0, "R9 status index 15", rdo, 32'h0);
    idle(9'h041); chk(rdo == 32'h0, "R9 misaligned status", rdo, 32'h0);
    cyc(1'b1, 9'h000, 32'hFFFF_0000, '0, '0, rdo, acco, rno);
    idle(9'h000); chk(rdo == 32'h0, "R9 gate upper bits", rdo, 32'h0);
    cyc(1'b1, 9'h000, 32'h0000_7FFF, '0, '0, rdo, acco, rno);

    // Mixed traffic against the model
    for (int k = 0; k < 600; k++) begin
      logic [8:0]  a;
      logic [31:0] wd;
      logic        we;
      int sel;
      sel = $urandom_range(0, 9);
      we  = (sel == 0);
      a   = (sel == 0) ? (($urandom_range(0, 1) == 0) ? 9'h000 : 9'h004)
          : 9'(64 + 4 * $urandom_range(0, N));
      wd  = 32'h7FFF & ~(32'h1 << $urandom_range(0, 14)) & ~(32'h1 << $urandom_range(0, 14));
      if (k % 50 == 49) begin we = 1'b1; wd = 32'h7FFF; end
      cyc(we, a, wd, 15'($urandom), 15'($urandom), rdo, acco, rno);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule